// File: doc/BRIEF.md
# Power-Loss Protection Sequencer

This block is the controller-side sequencer that protects a flash storage device when its supply falls away with no warning from the host. A comparator reports through `supply_ok_i` whether the supply is above its threshold. That signal is synchronised and filtered against glitches, and a sustained drop then triggers the sequence. The block stops accepting host writes and stops granting new flash operations, background ones included. It switches the hold-up energy path on and lets programs already in progress finish. In extended mode it then drains the write buffer and saves the logical-to-physical table. It ends in a safe state that persists until reset.

A cycle budget, loaded when the sequence triggers, limits the whole sequence to the time the hold-up energy lasts. If the budget runs out, the block flags a timeout and goes to the safe state anyway. A host shutdown command runs the same drain, flush and table save without hold-up energy and ends with an acknowledge. No data passes through the block. The flush and table-save interfaces are level request/done handshakes. The block holds a request high until it samples the matching done high at a rising edge, and a done that arrives while its request is low is ignored. The host and flash sides are plain enables that the front-end and scheduler combine with their own valid/ready flow.

Top module: `plp_sequencer`

## Requirements
- R1: `supply_ok_i` passes through two flops that reset to 1. A drop counts as a trigger only when the synchronised signal has been low for `cfg_filter_i` consecutive rising edges, and a value of 0 acts as 1. A shorter low pulse changes no output.
- R2: `host_wr_en_o` is 1 from reset. With a filter of 1 it goes to 0 on the third rising edge after `supply_ok_i` falls, and it stays 0.
- R3: `flash_op_grant_o` equals `flash_op_req_i` while the block is running, and is 0 from the same edge that clears `host_wr_en_o`.
- R4: `holdup_en_o` rises on the trigger edge and stays 1 until reset.
- R5: In basic mode (`cfg_extended_i`=0, sampled at the trigger), the block waits only for `flash_lower_busy_i` to go low and then reaches the safe state. It ignores `flash_upper_busy_i`, issues no flush or table save, and raises `upper_cancel_o` so that the scheduler drops an upper-page program that has not started.
- R6: In extended mode, the block waits until both busy inputs are low and then raises `flush_req_o`.
- R7: In extended mode, `tsave_req_o` rises only on the edge after a flush done is accepted. A table-save done then leads to the safe state.
- R8: A one-cycle `shdn_req_i` pulse while running runs the drain, flush and table save with `holdup_en_o` low and ends with `shdn_ack_o` held at 1. A supply drop after the acknowledge has no effect. A drop before the acknowledge turns the sequence into a power-loss sequence: hold-up is enabled, all steps still run, and the sequence ends in `safe_o` with no acknowledge.
- R9: A counter loaded with `cfg_budget_i` at the trigger counts down once per cycle. If it reaches 0 before the safe state, `timeout_o` is set, the requests drop, and `safe_o` is raised.
- R10: `safe_o` stays 1 until reset. A supply that recovers during the sequence does not abort it.
- R11: `flush_req_o` and `tsave_req_o` stay high until their done input is sampled high, unless the budget expires first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok_i | input | 1 | Comparator output, 1 while the supply is above threshold |
| cfg_extended_i | input | 1 | 1 selects extended mode (drain, flush and table save) |
| cfg_filter_i | input | FILT_W | Consecutive low cycles needed to trigger |
| cfg_budget_i | input | BUDGET_W | Hold-up budget in cycles |
| shdn_req_i | input | 1 | Host shutdown command pulse |
| shdn_ack_o | output | 1 | Shutdown finished, held until reset |
| host_wr_en_o | output | 1 | New host write commands may be accepted |
| flash_op_req_i | input | 1 | Scheduler wants to start a new flash operation |
| flash_op_grant_o | output | 1 | Permission to start that operation |
| flash_lower_busy_i | input | 1 | A lower-page program is in progress |
| flash_upper_busy_i | input | 1 | An upper-page program is in progress |
| upper_cancel_o | output | 1 | Drop upper-page programs not yet started |
| holdup_en_o | output | 1 | Enables the hold-up regulator |
| flush_req_o | output | 1 | Request to commit buffered write data |
| flush_done_i | input | 1 | Buffer flush complete |
| tsave_req_o | output | 1 | Request to save the address table |
| tsave_done_i | input | 1 | Table save complete |
| safe_o | output | 1 | Safe state reached, held until reset |
| timeout_o | output | 1 | Budget expired before the steps finished |

## Verification
The bench drives glitches one cycle shorter than the filter length and glitches of exactly that length, including a single-cycle glitch with the filter set to 0. A design with an off-by-one in the filter either triggers on noise or misses a real drop. It holds the upper-page busy high in basic mode while checking the safe state partway through the run, which catches a design that waits for the upper page. It lets the supply recover in the middle of a sequence, which catches a design that aborts. It runs budgets that expire during the drain and during the flush, which catches a design that hangs or forgets the timeout. The shutdown tests check that no hold-up energy is used, that a later drop is ignored once the acknowledge has been given, and that a drop before the acknowledge converts the sequence without skipping the table save.

// File: rtl/plp_pkg.sv
package plp_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_DRAIN,
    ST_FLUSH,
    ST_TSAVE,
    ST_SAFE,
    ST_SHDN_DONE
  } plp_state_e;
endpackage

// File: rtl/plp_drop_filter.sv
module plp_drop_filter #(
  parameter int FILT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok_i,
  input  logic [FILT_W-1:0] hold_cycles_i,
  output logic              fire_o
);
  logic [1:0]        sync_q;
  logic              low_s;
  logic [FILT_W-1:0] run_q;
  logic [FILT_W-1:0] need_m1;

  // two-flop synchroniser, reset to "supply good"
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], supply_ok_i};
  end

  assign low_s   = ~sync_q[1];
  assign need_m1 = (hold_cycles_i == '0) ? '0 : hold_cycles_i - FILT_W'(1);

  // consecutive-low run length, saturating
  always_ff @(posedge clk) begin
    if (!rst_n)              run_q <= '0;
    else if (!low_s)         run_q <= '0;
    else if (run_q != '1)    run_q <= run_q + FILT_W'(1);
  end

  assign fire_o = low_s && (run_q >= need_m1);

  // R1
  multi_cycle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && need_m1 != '0) |-> $past(low_s));
endmodule

// File: rtl/plp_budget_timer.sv
module plp_budget_timer #(
  parameter int BUDGET_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [BUDGET_W-1:0] budget_i,
  output logic                expired_o
);
  logic                running_q;
  logic [BUDGET_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      left_q    <= '0;
    end else if (start_i) begin
      running_q <= 1'b1;
      left_q    <= budget_i;
    end else if (running_q && left_q != '0) begin
      left_q <= left_q - BUDGET_W'(1);
    end
  end

  assign expired_o = running_q && (left_q == '0);

  // R9
  expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !start_i) |=> expired_o);
endmodule

// File: rtl/plp_seq_ctrl.sv
module plp_seq_ctrl
  import plp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drop_fire_i,
  input  logic tmr_expired_i,
  input  logic cfg_extended_i,
  input  logic shdn_req_i,
  input  logic flash_op_req_i,
  input  logic flash_lower_busy_i,
  input  logic flash_upper_busy_i,
  input  logic flush_done_i,
  input  logic tsave_done_i,
  output logic tmr_start_o,
  output logic host_wr_en_o,
  output logic flash_op_grant_o,
  output logic upper_cancel_o,
  output logic holdup_en_o,
  output logic flush_req_o,
  output logic tsave_req_o,
  output logic safe_o,
  output logic timeout_o,
  output logic shdn_ack_o
);
  plp_state_e state_q, state_d;
  logic plp_q, ext_q, shdn_q, timeout_q;
  logic start_plp, working, full_steps, drain_ok, expire_hit;

  assign working    = (state_q == ST_DRAIN) || (state_q == ST_FLUSH) ||
                      (state_q == ST_TSAVE);
  assign start_plp  = drop_fire_i && !plp_q && ((state_q == ST_RUN) || working);
  assign full_steps = ext_q || shdn_q;
  assign drain_ok   = !flash_lower_busy_i && (!full_steps || !flash_upper_busy_i);
  assign expire_hit = tmr_expired_i && working;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (start_plp || shdn_req_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (expire_hit)    state_d = ST_SAFE;
        else if (drain_ok) state_d = full_steps ? ST_FLUSH : ST_SAFE;
      end
      ST_FLUSH: begin
        if (expire_hit)        state_d = ST_SAFE;
        else if (flush_done_i) state_d = ST_TSAVE;
      end
      ST_TSAVE: begin
        if (expire_hit)        state_d = ST_SAFE;
        else if (tsave_done_i) state_d = (plp_q || start_plp) ? ST_SAFE : ST_SHDN_DONE;
      end
      ST_SAFE:      state_d = ST_SAFE;
      ST_SHDN_DONE: state_d = ST_SHDN_DONE;
      default:      state_d = ST_SAFE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      plp_q     <= 1'b0;
      ext_q     <= 1'b0;
      shdn_q    <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_plp) plp_q <= 1'b1;
      if (state_q == ST_RUN) begin
        ext_q <= cfg_extended_i;
        if (!start_plp && shdn_req_i) shdn_q <= 1'b1;
      end
      if (expire_hit) timeout_q <= 1'b1;
    end
  end

  assign tmr_start_o      = start_plp;
  assign host_wr_en_o     = (state_q == ST_RUN);
  assign flash_op_grant_o = flash_op_req_i && (state_q == ST_RUN);
  assign upper_cancel_o   = plp_q && !ext_q && !shdn_q;
  assign holdup_en_o      = plp_q;
  assign flush_req_o      = (state_q == ST_FLUSH);
  assign tsave_req_o      = (state_q == ST_TSAVE);
  assign safe_o           = (state_q == ST_SAFE);
  assign timeout_o        = timeout_q;
  assign shdn_ack_o       = (state_q == ST_SHDN_DONE);

  // R4
  holdup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holdup_en_o |=> holdup_en_o);

  // R10
  safe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    safe_o |=> safe_o);

  // R7
  tsave_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsave_req_o) |-> $past(flush_req_o && flush_done_i));

  // R9
  timeout_to_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired_i && working) |=> (safe_o && timeout_o));

  // R11
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req_o && !flush_done_i && !tmr_expired_i) |=> flush_req_o);

  // R3
  no_grant_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holdup_en_o || safe_o || shdn_ack_o) |-> !flash_op_grant_o);
endmodule

// File: rtl/plp_sequencer.sv
module plp_sequencer #(
  parameter int FILT_W   = 8,
  parameter int BUDGET_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                supply_ok_i,
  input  logic                cfg_extended_i,
  input  logic [FILT_W-1:0]   cfg_filter_i,
  input  logic [BUDGET_W-1:0] cfg_budget_i,
  input  logic                shdn_req_i,
  output logic                shdn_ack_o,
  output logic                host_wr_en_o,
  input  logic                flash_op_req_i,
  output logic                flash_op_grant_o,
  input  logic                flash_lower_busy_i,
  input  logic                flash_upper_busy_i,
  output logic                upper_cancel_o,
  output logic                holdup_en_o,
  output logic                flush_req_o,
  input  logic                flush_done_i,
  output logic                tsave_req_o,
  input  logic                tsave_done_i,
  output logic                safe_o,
  output logic                timeout_o
);
  logic drop_fire;
  logic tmr_start;
  logic tmr_expired;

  plp_drop_filter #(.FILT_W(FILT_W)) u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok_i),
    .hold_cycles_i (cfg_filter_i),
    .fire_o        (drop_fire)
  );

  plp_budget_timer #(.BUDGET_W(BUDGET_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (tmr_start),
    .budget_i  (cfg_budget_i),
    .expired_o (tmr_expired)
  );

  plp_seq_ctrl u_ctrl (
    .clk                (clk),
    .rst_n              (rst_n),
    .drop_fire_i        (drop_fire),
    .tmr_expired_i      (tmr_expired),
    .cfg_extended_i     (cfg_extended_i),
    .shdn_req_i         (shdn_req_i),
    .flash_op_req_i     (flash_op_req_i),
    .flash_lower_busy_i (flash_lower_busy_i),
    .flash_upper_busy_i (flash_upper_busy_i),
    .flush_done_i       (flush_done_i),
    .tsave_done_i       (tsave_done_i),
    .tmr_start_o        (tmr_start),
    .host_wr_en_o       (host_wr_en_o),
    .flash_op_grant_o   (flash_op_grant_o),
    .upper_cancel_o     (upper_cancel_o),
    .holdup_en_o        (holdup_en_o),
    .flush_req_o        (flush_req_o),
    .tsave_req_o        (tsave_req_o),
    .safe_o             (safe_o),
    .timeout_o          (timeout_o),
    .shdn_ack_o         (shdn_ack_o)
  );

  // R1
  trigger_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdup_en_o) |-> $past(drop_fire));
endmodule

// File: tb/plp_sequencer_bench.sv
`timescale 1ns/1ps
module plp_sequencer_bench;
  localparam int FILT_W   = 8;
  localparam int BUDGET_W = 20;
  localparam int WIN      = 400;
  localparam int MID      = 70;
  localparam int PERM     = 511;

  typedef struct packed {
    logic        ext;
    logic [7:0]  filt;
    logic [9:0]  glen;
    logic [9:0]  lb;
    logic [9:0]  ub;
    logic [9:0]  fl;
    logic [9:0]  ts;
    logic [19:0] bud;
    logic        e_trig;
    logic        e_mid;
    logic        e_safe;
    logic        e_to;
    logic        e_fl;
    logic        e_ts;
  } vec_t;

  // ext filt glen lb ub fl ts budget | trig mid safe to fl ts
  localparam vec_t VECS [8] = '{
    '{1'b0, 8'd4, 10'd3,   10'd20,  10'd100, 10'd0,   10'd0,  20'd1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 8'd4, 10'd4,   10'd20,  10'd100, 10'd0,   10'd0,  20'd1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd2, 10'd511, 10'd20,  10'd60,  10'd10,  10'd10, 20'd1000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'd1, 10'd511, 10'd10,  10'd10,  10'd500, 10'd10, 20'd50,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 8'd3, 10'd10,  10'd30,  10'd30,  10'd5,   10'd5,  20'd1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b0, 8'd1, 10'd511, 10'd300, 10'd0,   10'd0,   10'd0,  20'd100,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'd8, 10'd7,   10'd10,  10'd10,  10'd3,   10'd3,  20'd1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd0, 10'd1,   10'd0,   10'd0,   10'd3,   10'd3,  20'd1000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                supply_ok = 1'b1;
  logic                cfg_ext = 1'b0;
  logic [FILT_W-1:0]   cfg_filt = 8'd1;
  logic [BUDGET_W-1:0] cfg_bud = 20'd1000;
  logic                shdn_req = 1'b0;
  logic                shdn_ack;
  logic                host_wr_en;
  logic                op_req = 1'b1;
  logic                op_grant;
  logic                lower_busy = 1'b0;
  logic                upper_busy = 1'b0;
  logic                upper_cancel;
  logic                holdup_en;
  logic                flush_req;
  logic                flush_done = 1'b0;
  logic                tsave_req;
  logic                tsave_done = 1'b0;
  logic                safe;
  logic                timeout;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  plp_sequencer #(.FILT_W(FILT_W), .BUDGET_W(BUDGET_W)) u_plp_sequencer (
    .clk                (clk),
    .rst_n              (rst_n),
    .supply_ok_i        (supply_ok),
    .cfg_extended_i     (cfg_ext),
    .cfg_filter_i       (cfg_filt),
    .cfg_budget_i       (cfg_bud),
    .shdn_req_i         (shdn_req),
    .shdn_ack_o         (shdn_ack),
    .host_wr_en_o       (host_wr_en),
    .flash_op_req_i     (op_req),
    .flash_op_grant_o   (op_grant),
    .flash_lower_busy_i (lower_busy),
    .flash_upper_busy_i (upper_busy),
    .upper_cancel_o     (upper_cancel),
    .holdup_en_o        (holdup_en),
    .flush_req_o        (flush_req),
    .flush_done_i       (flush_done),
    .tsave_req_o        (tsave_req),
    .tsave_done_i       (tsave_done),
    .safe_o             (safe),
    .timeout_o          (timeout)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    supply_ok = 1'b1; shdn_req = 1'b0; lower_busy = 1'b0; upper_busy = 1'b0;
    flush_done = 1'b0; tsave_done = 1'b0; op_req = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // per-cycle stimulus and done responders, all driven at the falling edge
  task automatic run_window(input int ncyc, input int drop_at, input int glen,
                            input int lb, input int ub, input int fl, input int ts,
                            input int shdn_at, input int mid_at,
                            output bit fl_seen, output bit ts_seen, output bit mid_safe);
    int fcnt;
    int tcnt;
    fcnt = 0; tcnt = 0;
    fl_seen = 1'b0; ts_seen = 1'b0; mid_safe = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      supply_ok  = !(drop_at >= 0 && c >= drop_at && (glen >= PERM || c < drop_at + glen));
      lower_busy = (c < lb);
      upper_busy = (c < ub);
      shdn_req   = (c == shdn_at);
      if (flush_req) begin
        fl_seen = 1'b1; flush_done = (fcnt >= fl); fcnt++;
      end else flush_done = 1'b0;
      if (tsave_req) begin
        ts_seen = 1'b1; tsave_done = (tcnt >= ts); tcnt++;
      end else tsave_done = 1'b0;
      if (c == mid_at) mid_safe = safe;
    end
    @(negedge clk);
    flush_done = 1'b0; tsave_done = 1'b0; shdn_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit fs, ts_s, ms;

    // reset state: R2 R3 R4 R10 R9 R8
    do_reset();
    @(negedge clk);
    chk("R2 reset host_wr_en", host_wr_en, 1);
    chk("R3 reset grant follows req", op_grant, 1);
    chk("R4 reset holdup", holdup_en, 0);
    chk("R10 reset safe", safe, 0);
    chk("R9 reset timeout", timeout, 0);
    chk("R8 reset ack", shdn_ack, 0);
    chk("R11 reset flush_req", flush_req, 0);

    // table of vectors
    foreach (VECS[i]) begin
      cfg_ext  = VECS[i].ext;
      cfg_filt = VECS[i].filt;
      cfg_bud  = VECS[i].bud;
      do_reset();
      run_window(WIN, 5, int'(VECS[i].glen), int'(VECS[i].lb), int'(VECS[i].ub),
                 int'(VECS[i].fl), int'(VECS[i].ts), -1, MID, fs, ts_s, ms);
      chk($sformatf("R1 R2 v%0d host_wr_en", i), host_wr_en, !VECS[i].e_trig);
      chk($sformatf("R3 v%0d grant", i), op_grant, !VECS[i].e_trig);
      chk($sformatf("R4 v%0d holdup", i), holdup_en, VECS[i].e_trig);
      chk($sformatf("R5 v%0d safe at mid", i), ms, VECS[i].e_mid);
      chk($sformatf("R10 v%0d safe", i), safe, VECS[i].e_safe);
      chk($sformatf("R9 v%0d timeout", i), timeout, VECS[i].e_to);
      chk($sformatf("R6 v%0d flush seen", i), fs, VECS[i].e_fl);
      chk($sformatf("R7 v%0d tsave seen", i), ts_s, VECS[i].e_ts);
      chk($sformatf("R5 v%0d upper_cancel", i), upper_cancel,
          VECS[i].e_trig && !VECS[i].ext);
      chk($sformatf("R11 v%0d requests idle", i), flush_req | tsave_req, 0);
    end

    // R2 R3 exact trigger latency with filter 1
    cfg_filt = 8'd1; cfg_ext = 1'b1; cfg_bud = 20'd1000;
    do_reset();
    @(negedge clk);
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 still enabled after two edges", host_wr_en, 1);
    @(negedge clk);
    chk("R2 disabled on third edge", host_wr_en, 0);
    chk("R3 grant blocked on third edge", op_grant, 0);
    chk("R4 holdup on third edge", holdup_en, 1);

    // R8 shutdown path, then a drop after the acknowledge
    do_reset();
    run_window(100, -1, 0, 10, 12, 2, 2, 2, -1, fs, ts_s, ms);
    chk("R8 shutdown ack", shdn_ack, 1);
    chk("R8 shutdown holdup off", holdup_en, 0);
    chk("R8 shutdown not safe", safe, 0);
    chk("R8 shutdown flushed", fs, 1);
    chk("R8 shutdown table saved", ts_s, 1);
    run_window(30, 0, PERM, 0, 0, 0, 0, -1, -1, fs, ts_s, ms);
    chk("R8 drop after ack holdup", holdup_en, 0);
    chk("R8 drop after ack still acked", shdn_ack, 1);

    // R8 drop during shutdown converts it, steps still complete
    cfg_ext = 1'b0;
    do_reset();
    run_window(150, 20, PERM, 5, 5, 40, 2, 2, -1, fs, ts_s, ms);
    chk("R8 converted holdup", holdup_en, 1);
    chk("R8 converted safe", safe, 1);
    chk("R8 converted no ack", shdn_ack, 0);
    chk("R8 converted table saved", ts_s, 1);
    chk("R9 converted no timeout", timeout, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule